// File: doc/BRIEF.md
# Bitmask Membership Branch Condition Unit

This unit decides whether a conditional branch is taken by asking whether a source operand belongs to a small set of values. The set is a bitmask in which each bit position stands for one operand value. If the bit that the operand selects is 1, the branch is taken. One mask of this kind replaces a chain of separate equality branches, such as "equals 3, 6 or 9", and it can also skip chosen iterations of a loop.

The mask comes from one of two sources. It is either a 32-bit immediate or a 64-bit register value, and the width in use follows that choice. In unsigned mode the operand is the bit index. In signed mode the bit index is the operand minus a base value. The base has a default for each width, or it can be supplied at run time. Any operand that lands outside the mask gives not-taken.

A request strobe samples all inputs. The decision appears one clock later, together with a valid flag.

Top module: `mask_branch_unit`

## Requirements
- R1: When the selected bit index `k` is inside the mask, `taken` equals bit `k` of the active mask. Bit 0 is the least significant bit.
- R2: In unsigned mode (`signed_mode`=0), the whole 64-bit operand is an unsigned index.
  - With the immediate mask, values 0..31 are in range.
  - With the register mask, values 0..63 are in range.
  - Any larger value gives not-taken.
- R3: In signed mode with `custom_base_en`=0, the index is the operand minus a default base. The base is -15 for the immediate mask (range -15..16) and -31 for the register mask (range -31..32). Operands outside that range give not-taken.
- R4: In signed mode with `custom_base_en`=1, the base is the signed value on `custom_base`, and the in-range values are `custom_base` to `custom_base`+width-1.
- R5: In signed mode the difference is formed without wrap-around. Operands near the 64-bit signed extremes never alias into range.
- R6: `use_reg_mask`=1 selects the 64-bit `mask_reg`. `use_reg_mask`=0 selects `mask_imm`, zero-extended. The mask that is not selected has no effect on the result.
- R7: A request sampled on a rising edge gives `result_valid`=1 and its `taken` after that same edge. A cycle with no request gives `result_valid`=0 and `taken`=0 after the next edge.
- R8: A synchronous active-high `rst` clears `result_valid` and `taken`, and it overrides a request in the same cycle.
- R9: Two examples must hold.
  - Mask 0x26 gives taken for operands 1 and 2, and not-taken for 0 and 3.
  - Mask 0x248 gives taken only for operands 3, 6 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; samples all inputs |
| src_operand | input | 64 | Value tested against the mask |
| mask_imm | input | 32 | Immediate mask |
| mask_reg | input | 64 | Register mask |
| use_reg_mask | input | 1 | 1 selects `mask_reg`, 0 selects `mask_imm` |
| signed_mode | input | 1 | 1 selects signed indexing with a base |
| custom_base_en | input | 1 | 1 uses `custom_base` instead of the default base |
| custom_base | input | 64 | Signed base value for signed mode |
| taken | output | 1 | Registered branch decision |
| result_valid | output | 1 | Registered strobe marking `taken` as meaningful |

## Verification
Both outputs come from one register stage, so each result is due exactly one rising edge after its request is sampled.

The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then reads `taken` and `result_valid` on the following falling edge, where the result of that request is stable. It drops the strobe at that point, so an idle cycle can be checked for `result_valid` returning low after the next edge.

The sweeps cover every in-range index plus one value on each side of the range, for both widths, both modes and several bases. The expected values are computed arithmetically with signed 64-bit integers.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    parameter int unsigned OPND_W     = 64;
    parameter int unsigned IMM_MASK_W = 32;
    parameter int unsigned REG_MASK_W = 64;

    localparam int unsigned IDX_W  = $clog2(REG_MASK_W);
    localparam int unsigned CNT_W  = IDX_W + 1;
    localparam int unsigned DIFF_W = OPND_W + 1;

    typedef enum logic {
        MSRC_IMM = 1'b0,
        MSRC_REG = 1'b1
    } mask_src_e;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic [REG_MASK_W-1:0] bits;
        logic [CNT_W-1:0]      width;
    } mask_info_t;

    typedef struct packed {
        logic             in_range;
        logic [IDX_W-1:0] index;
    } slot_t;

    // Default signed base: the lowest value sits at -(width/2 - 1).
    function automatic logic [OPND_W-1:0] default_base(input logic [CNT_W-1:0] w);
        logic [OPND_W-1:0] half;
        half = OPND_W'(w >> 1);
        return OPND_W'(0) - (half - OPND_W'(1));
    endfunction

    // Sign-extend an operand by one bit so that subtraction cannot wrap.
    function automatic logic [DIFF_W-1:0] sext1(input logic [OPND_W-1:0] v);
        return {v[OPND_W-1], v};
    endfunction

endpackage

// File: rtl/mbr_mask_select.sv
module mbr_mask_select
    import mbr_pkg::*;
(
    input  mask_src_e               src_sel,
    input  logic [IMM_MASK_W-1:0]   imm_bits,
    input  logic [REG_MASK_W-1:0]   reg_bits,
    output mask_info_t              info
);

    localparam int unsigned PAD_W = REG_MASK_W - IMM_MASK_W;

    logic [REG_MASK_W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm_bits};
        end else begin : g_nopad
            assign imm_ext = imm_bits[REG_MASK_W-1:0];
        end
    endgenerate

    always_comb begin
        if (src_sel == MSRC_REG) begin
            info.bits  = reg_bits;
            info.width = CNT_W'(REG_MASK_W);
        end else begin
            info.bits  = imm_ext;
            info.width = CNT_W'(IMM_MASK_W);
        end
    end

endmodule

// File: rtl/mbr_index_calc.sv
module mbr_index_calc
    import mbr_pkg::*;
(
    input  cmp_mode_e           mode,
    input  logic [OPND_W-1:0]   operand,
    input  logic                base_override,
    input  logic [OPND_W-1:0]   base_value,
    input  logic [CNT_W-1:0]    width,
    output slot_t               slot
);

    logic [OPND_W-1:0] base_eff;
    logic [DIFF_W-1:0] diff;
    logic              signed_ok;
    logic              unsigned_ok;

    always_comb begin
        base_eff    = base_override ? base_value : default_base(width);
        diff        = sext1(operand) - sext1(base_eff);
        // Non-negative and below the mask width.
        signed_ok   = !diff[DIFF_W-1] && (diff < DIFF_W'(width));
        unsigned_ok = operand < OPND_W'(width);

        if (mode == CMP_SIGNED) begin
            slot.in_range = signed_ok;
            slot.index    = diff[IDX_W-1:0];
        end else begin
            slot.in_range = unsigned_ok;
            slot.index    = operand[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/mbr_bit_pick.sv
module mbr_bit_pick
    import mbr_pkg::*;
(
    input  logic [REG_MASK_W-1:0] bits,
    input  slot_t                 slot,
    output logic                  hit
);

    always_comb begin
        hit = slot.in_range & bits[slot.index];
    end

endmodule

// File: rtl/mask_branch_unit.sv
module mask_branch_unit
    import mbr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [OPND_W-1:0]     src_operand,
    input  logic [IMM_MASK_W-1:0] mask_imm,
    input  logic [REG_MASK_W-1:0] mask_reg,
    input  logic                  use_reg_mask,
    input  logic                  signed_mode,
    input  logic                  custom_base_en,
    input  logic [OPND_W-1:0]     custom_base,
    output logic                  taken,
    output logic                  result_valid
);

    mask_src_e  src_sel;
    cmp_mode_e  mode;
    mask_info_t minfo;
    slot_t      slot;
    logic       hit;
    logic       taken_q;
    logic       valid_q;

    assign src_sel = use_reg_mask ? MSRC_REG : MSRC_IMM;
    assign mode    = signed_mode  ? CMP_SIGNED : CMP_UNSIGNED;

    mbr_mask_select u_msel (
        .src_sel  (src_sel),
        .imm_bits (mask_imm),
        .reg_bits (mask_reg),
        .info     (minfo)
    );

    mbr_index_calc u_idx (
        .mode          (mode),
        .operand       (src_operand),
        .base_override (custom_base_en),
        .base_value    (custom_base),
        .width         (minfo.width),
        .slot          (slot)
    );

    mbr_bit_pick u_pick (
        .bits (minfo.bits),
        .slot (slot),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            taken_q <= 1'b0;
        end else begin
            valid_q <= req_valid;
            taken_q <= req_valid & hit;
        end
    end

    assign taken        = taken_q;
    assign result_valid = valid_q;

endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
    import mbr_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [OPND_W-1:0]     src_operand,
    input logic [IMM_MASK_W-1:0] mask_imm,
    input logic [REG_MASK_W-1:0] mask_reg,
    input logic                  use_reg_mask,
    input logic                  signed_mode,
    input logic                  taken,
    input logic                  result_valid
);

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rst) |=> result_valid); // R7

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !rst) |=> !result_valid); // R7

    AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> !taken); // R7

    AST_UNS_REG_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !signed_mode && use_reg_mask &&
         src_operand >= OPND_W'(REG_MASK_W)) |=> !taken); // R2

    AST_UNS_IMM_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !signed_mode && !use_reg_mask &&
         src_operand >= OPND_W'(IMM_MASK_W)) |=> !taken); // R2

    AST_EMPTY_IMM_MASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !use_reg_mask && mask_imm == '0) |=> !taken); // R6

    AST_EMPTY_REG_MASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && use_reg_mask && mask_reg == '0) |=> !taken); // R6

endmodule

bind mask_branch_unit mbr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .src_operand  (src_operand),
    .mask_imm     (mask_imm),
    .mask_reg     (mask_reg),
    .use_reg_mask (use_reg_mask),
    .signed_mode  (signed_mode),
    .taken        (taken),
    .result_valid (result_valid)
);

// File: tb/mask_branch_unit_test.sv
module mask_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] src_operand = '0;
    logic [31:0] mask_imm = '0;
    logic [63:0] mask_reg = '0;
    logic        use_reg_mask = 1'b0;
    logic        signed_mode = 1'b0;
    logic        custom_base_en = 1'b0;
    logic [63:0] custom_base = '0;
    logic        taken;
    logic        result_valid;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mask_branch_unit uut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .src_operand    (src_operand),
        .mask_imm       (mask_imm),
        .mask_reg       (mask_reg),
        .use_reg_mask   (use_reg_mask),
        .signed_mode    (signed_mode),
        .custom_base_en (custom_base_en),
        .custom_base    (custom_base),
        .taken          (taken),
        .result_valid   (result_valid)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Reference decision built from the requirement text, using signed integers.
    function automatic logic expect_taken(input logic sel, input logic smode,
                                          input logic cen, input longint base,
                                          input logic [63:0] op,
                                          input logic [31:0] imm,
                                          input logic [63:0] regm);
        longint     w;
        logic [63:0] m;
        longint     b;
        longint     so;
        w = sel ? 64 : 32;
        m = sel ? regm : {32'h0, imm};
        if (!smode) begin
            if (op >= 64'(w)) return 1'b0;
            return m[int'(op)];
        end
        b  = cen ? base : (sel ? -64'sd31 : -64'sd15);
        so = longint'(op);
        if (so < b || so > b + w - 1) return 1'b0;
        return m[int'(so - b)];
    endfunction

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic request(input string req, input logic sel, input logic smode,
                           input logic cen, input longint base,
                           input logic [63:0] op, input logic [31:0] imm,
                           input logic [63:0] regm);
        logic exp;
        req_valid      = 1'b1;
        use_reg_mask   = sel;
        signed_mode    = smode;
        custom_base_en = cen;
        custom_base    = 64'(base);
        src_operand    = op;
        mask_imm       = imm;
        mask_reg       = regm;
        exp = expect_taken(sel, smode, cen, base, op, imm, regm);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, $sformatf("taken op=%0d sel=%0b sgn=%0b cen=%0b base=%0d",
                             longint'(op), sel, smode, cen, base), taken, exp);
        check("R7", "valid after request", result_valid, 1'b1);
    endtask

    task automatic sweep(input string req, input logic sel, input logic smode,
                         input logic cen, input longint base,
                         input logic [31:0] imm, input logic [63:0] regm);
        longint w;
        longint lo;
        w  = sel ? 64 : 32;
        lo = !smode ? 0 : (cen ? base : (sel ? -64'sd31 : -64'sd15));
        for (longint v = lo - 1; v <= lo + w; v++) begin
            if (!smode && v < 0) continue;
            request(req, sel, smode, cen, base, 64'(v), imm, regm);
        end
    endtask

    localparam logic [63:0] REG_A = 64'hC3A5_96F0_0F69_5A3C;
    localparam logic [31:0] IMM_A = 32'h9B2D_61E7;

    initial begin
        // R8: reset holds outputs low even with a request present.
        @(negedge clk);
        req_valid = 1'b1;
        mask_imm  = 32'hFFFF_FFFF;
        src_operand = 64'd1;
        @(posedge clk);
        @(negedge clk);
        check("R8", "valid under reset", result_valid, 1'b0);
        check("R8", "taken under reset", taken, 1'b0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R9 examples
        request("R9", 1'b0, 1'b0, 1'b0, 0, 64'd0, 32'h26, ~64'h0);
        request("R9", 1'b0, 1'b0, 1'b0, 0, 64'd1, 32'h26, ~64'h0);
        request("R9", 1'b0, 1'b0, 1'b0, 0, 64'd2, 32'h26, ~64'h0);
        request("R9", 1'b0, 1'b0, 1'b0, 0, 64'd3, 32'h26, ~64'h0);
        for (int v = 0; v < 12; v++) begin
            request("R9", 1'b1, 1'b0, 1'b0, 0, 64'(v), 32'hFFFF_FFFF, 64'h248);
        end

        // R1/R2: unsigned sweeps, both widths, two mask patterns; unused mask opposite (R6)
        sweep("R2", 1'b0, 1'b0, 1'b0, 0, IMM_A, ~REG_A);
        sweep("R1", 1'b0, 1'b0, 1'b0, 0, ~IMM_A, REG_A);
        sweep("R2", 1'b1, 1'b0, 1'b0, 0, ~IMM_A, REG_A);
        sweep("R1", 1'b1, 1'b0, 1'b0, 0, IMM_A, ~REG_A);

        // R3: signed default base
        sweep("R3", 1'b0, 1'b1, 1'b0, 0, IMM_A, ~REG_A);
        sweep("R3", 1'b0, 1'b1, 1'b0, 0, ~IMM_A, REG_A);
        sweep("R3", 1'b1, 1'b1, 1'b0, 0, ~IMM_A, REG_A);
        sweep("R3", 1'b1, 1'b1, 1'b0, 0, IMM_A, ~REG_A);

        // R4: non-default bases
        sweep("R4", 1'b0, 1'b1, 1'b1, -5, IMM_A, REG_A);
        sweep("R4", 1'b1, 1'b1, 1'b1, 20, IMM_A, REG_A);
        sweep("R4", 1'b1, 1'b1, 1'b1, -40, ~IMM_A, ~REG_A);
        sweep("R4", 1'b0, 1'b1, 1'b1, 7, ~IMM_A, ~REG_A);

        // R5: extreme operands with all-ones masks
        request("R5", 1'b1, 1'b1, 1'b0, 0, 64'h8000_0000_0000_0000, 32'hFFFF_FFFF, ~64'h0);
        request("R5", 1'b1, 1'b1, 1'b0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, ~64'h0);
        request("R5", 1'b0, 1'b1, 1'b0, 0, 64'h8000_0000_0000_0005, 32'hFFFF_FFFF, ~64'h0);
        request("R5", 1'b1, 1'b1, 1'b1, 64'sh7FFF_FFFF_FFFF_FFF0,
                64'h8000_0000_0000_0002, 32'hFFFF_FFFF, ~64'h0);
        request("R5", 1'b1, 1'b1, 1'b1, -64'sh7FFF_FFFF_FFFF_FFF0,
                64'h7FFF_FFFF_FFFF_FFF5, 32'hFFFF_FFFF, ~64'h0);
        request("R2", 1'b1, 1'b0, 1'b0, 0, 64'h1_0000_0003, 32'hFFFF_FFFF, ~64'h0);
        request("R2", 1'b0, 1'b0, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, ~64'h0);

        // R6: the unselected mask has no effect
        request("R6", 1'b0, 1'b0, 1'b0, 0, 64'd5, 32'h0, ~64'h0);
        request("R6", 1'b1, 1'b0, 1'b0, 0, 64'd5, 32'hFFFF_FFFF, 64'h0);
        request("R6", 1'b1, 1'b0, 1'b0, 0, 64'd40, 32'h0, 64'h0000_0100_0000_0000);

        // R7: idle cycle drops valid and taken
        request("R7", 1'b0, 1'b0, 1'b0, 0, 64'd3, 32'hFFFF_FFFF, ~64'h0);
        @(posedge clk);
        @(negedge clk);
        check("R7", "valid after idle cycle", result_valid, 1'b0);
        check("R7", "taken after idle cycle", taken, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule